// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the bookkeeping for four ring buffers of 32-bit entries held in external memory. The rings are a free ring and a post ring in each direction: inbound free, inbound post, outbound post and outbound free. All four share one base address and one size code. Ring q occupies the region that starts q region-sizes above the base. A region-size is the size code times 16 KiB.

A processor programs the block through a small register port. It can set the enable bit and size code, the 1 MiB-aligned base, and the head and tail offset of every ring. The bus-facing agent moves one pointer of each ring through an advance strobe. For each ring the block presents the byte address that this agent should access next. It flags empty and full per ring, refuses advances that would overrun or underrun a ring, and pulses when a new entry lands on the inbound post ring. That pulse is meant to feed an interrupt cause bit. The memory data path lies outside the block.

Top module: `cq_ptr_mgr`

## Requirements
- R1: Register address 0 is the control register. Bit 0 is the enable and bits 5:1 are the size code. It reads back as written, other bits read 0, and it holds its value when it is not written.
- R2: Register address 1 is the base. Only written bits 31:20 are kept, and bits 19:0 read 0.
- R3: Ring q (0 inbound free, 1 inbound post, 2 outbound post, 3 outbound free) keeps its head offset at address 2+2q and its tail offset at address 3+2q. A write stores bits 20:2 of the data, so bits 1:0 and bits 31:21 read 0.
- R4: An accepted advance adds 4 to the ring's hardware-driven pointer. The pointer is reset to the region start (q·code·16384) when the sum reaches start + code·16384.
- R5: Strobe bit q moves the head of rings 1 and 3 and the tail of rings 0 and 2. Address lane q (bits 32q+31:32q of hw_addr) equals base + that pointer.
- R6: Ring q is empty when head equals tail. It is full when the size code is nonzero and the head, advanced by 4 with wrap, equals the tail.
- R7: An advance is refused on a full ring when it drives the head, and on an empty ring when it drives the tail. The pointer then keeps its value and hw_err bit q is 1 for exactly the next cycle.
- R8: While the enable bit is 0 or the size code is 0, strobes move nothing and raise neither hw_err nor the post pulse.
- R9: An accepted advance of ring 1 makes ip_post_pulse 1 for exactly the next cycle.
- R10: A processor write and a strobe may fall in the same cycle. Acceptance is judged on the old pointers. A write to the strobed pointer stores the written value. A write to the other pointer of that ring stores the written value while the advance still takes effect.
- R11: After reset all registers read 0, every ring is empty and none is full, and hw_err, ip_post_pulse and hw_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register index for read and write |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational on cpu_addr |
| hw_adv | input | 4 | Per-ring advance strobes from the bus-side agent |
| hw_addr | output | 128 | Per-ring next access byte address, lane q in bits 32q+31:32q |
| q_empty | output | 4 | Per-ring empty flag |
| q_full | output | 4 | Per-ring full flag |
| hw_err | output | 4 | Per-ring refused-advance pulse |
| ip_post_pulse | output | 1 | New entry on the inbound post ring |

## Verification
Two things can land on one pointer in the same cycle: a processor register write and a strobe from the bus-side agent. The bench drives both on a single clock edge on the inbound post ring. In the first case the head is written while the head is strobed, and the bench expects the written head value together with a post pulse. In the second case the tail is written while the head is strobed, and the bench expects the stepped head and the new tail. Around this, every ring is swept under three size codes through its wrap point into the full or empty refusal. At each step the arithmetic model in the bench predicts the address lane, the flags and the pulses.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CQ_NQ     = 4;
  localparam int CQ_CODE_W = 5;

  typedef enum logic [1:0] {
    RING_IN_FREE  = 2'd0,
    RING_IN_POST  = 2'd1,
    RING_OUT_POST = 2'd2,
    RING_OUT_FREE = 2'd3
  } ring_id_e;

  // bytes in one ring region
  function automatic logic [31:0] cq_region_size(input logic [CQ_CODE_W-1:0] code,
                                                 input int unsigned shift);
    return 32'(code) << shift;
  endfunction

  // first byte offset of ring q relative to the base
  function automatic logic [31:0] cq_region_start(input logic [CQ_CODE_W-1:0] code,
                                                  input int unsigned q,
                                                  input int unsigned shift);
    return 32'(q) * cq_region_size(code, shift);
  endfunction

  // one entry forward, folding back to the region start at the region end
  function automatic logic [31:0] cq_step(input logic [31:0] ptr,
                                          input logic [31:0] start,
                                          input logic [31:0] size);
    logic [31:0] nxt;
    nxt = ptr + 32'd4;
    return (nxt >= start + size) ? start : nxt;
  endfunction
endpackage

// File: rtl/cq_ctrl_regs.sv
module cq_ctrl_regs #(
  parameter int CODE_W    = 5,
  parameter int BASE_KEEP = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_ctrl,
  input  logic                 we_base,
  input  logic [CODE_W:0]      ctrl_wdata,
  input  logic [BASE_KEEP-1:0] base_wdata,
  output logic                 en,
  output logic [CODE_W-1:0]    code,
  output logic [BASE_KEEP-1:0] base_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      code    <= '0;
      base_hi <= '0;
    end else begin
      if (we_ctrl) begin
        en   <= ctrl_wdata[0];
        code <= ctrl_wdata[CODE_W:1];
      end
      if (we_base) base_hi <= base_wdata;
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ctrl |=> $stable(en) && $stable(code)); // R1
  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_base |=> $stable(base_hi)); // R2
endmodule

// File: rtl/cq_queue.sv
module cq_queue
  import cq_pkg::*;
#(
  parameter int   Q          = 0,
  parameter int   CODE_W     = 5,
  parameter int   PTR_W      = 21,
  parameter int   UNIT_SHIFT = 14,
  parameter logic HW_ON_HEAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic              we_head,
  input  logic              we_tail,
  input  logic [PTR_W-1:0]  wval,
  input  logic              hw_adv,
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W-1:0]  tail,
  output logic [PTR_W-1:0]  hw_ptr,
  output logic              empty,
  output logic              full,
  output logic              err_q,
  output logic              acc_q
);
  logic [31:0] start32, size32, head_step32, hw_next32;
  logic        blocked, hw_we, acc, refuse;

  always_comb begin
    start32     = cq_region_start(code, Q, UNIT_SHIFT);
    size32      = cq_region_size(code, UNIT_SHIFT);
    head_step32 = cq_step(32'(head), start32, size32);
  end

  assign empty = (head == tail);
  assign full  = (code != '0) && (head_step32 == 32'(tail));

  generate
    if (HW_ON_HEAD) begin : g_head_side
      assign blocked   = full;
      assign hw_ptr    = head;
      assign hw_we     = we_head;
      assign hw_next32 = head_step32;
    end else begin : g_tail_side
      assign blocked   = empty;
      assign hw_ptr    = tail;
      assign hw_we     = we_tail;
      assign hw_next32 = cq_step(32'(tail), start32, size32);
    end
  endgenerate

  assign acc    = hw_adv && run && !blocked;
  assign refuse = hw_adv && run && blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      err_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      if (we_head)                head <= wval;
      else if (acc && HW_ON_HEAD) head <= PTR_W'(hw_next32);
      if (we_tail)                 tail <= wval;
      else if (acc && !HW_ON_HEAD) tail <= PTR_W'(hw_next32);
      err_q <= refuse;
      acc_q <= acc;
    end
  end

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !hw_we |=> (hw_ptr == $past(hw_ptr) + PTR_W'(4)) ||
                      (32'(hw_ptr) == $past(start32))); // R4
  AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_adv && !acc && !hw_we |=> $stable(hw_ptr)); // R7
  AST_ERR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(run && hw_adv)); // R8
  AST_ERR_ACC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && acc_q)); // R7
endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
  import cq_pkg::*;
#(
  parameter int UNIT_SHIFT = 14,
  parameter int BASE_KEEP  = 12,
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_we,
  input  logic [REG_AW-1:0]        cpu_addr,
  input  logic [ADDR_W-1:0]        cpu_wdata,
  output logic [ADDR_W-1:0]        cpu_rdata,
  input  logic [CQ_NQ-1:0]         hw_adv,
  output logic [CQ_NQ*ADDR_W-1:0]  hw_addr,
  output logic [CQ_NQ-1:0]         q_empty,
  output logic [CQ_NQ-1:0]         q_full,
  output logic [CQ_NQ-1:0]         hw_err,
  output logic                     ip_post_pulse
);
  localparam int NQ       = CQ_NQ;
  localparam int CODE_W   = CQ_CODE_W;
  localparam int PTR_W    = CODE_W + UNIT_SHIFT + 2;
  localparam int LOW_ZERO = ADDR_W - BASE_KEEP;

  logic                 en, run;
  logic [CODE_W-1:0]    code;
  logic [BASE_KEEP-1:0] base_hi;
  logic                 we_ctrl, we_base;
  logic [NQ-1:0]        we_head, we_tail, acc_q;
  logic [PTR_W-1:0]     head_r [NQ];
  logic [PTR_W-1:0]     tail_r [NQ];
  logic [PTR_W-1:0]     hwp    [NQ];
  logic [PTR_W-1:0]     wval;

  assign we_ctrl = cpu_we && (cpu_addr == REG_AW'(0));
  assign we_base = cpu_we && (cpu_addr == REG_AW'(1));
  assign wval    = {cpu_wdata[PTR_W-1:2], 2'b00};
  assign run     = en && (code != '0);

  cq_ctrl_regs #(.CODE_W(CODE_W), .BASE_KEEP(BASE_KEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_ctrl(we_ctrl), .we_base(we_base),
    .ctrl_wdata(cpu_wdata[CODE_W:0]),
    .base_wdata(cpu_wdata[ADDR_W-1 -: BASE_KEEP]),
    .en(en), .code(code), .base_hi(base_hi)
  );

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_ring
      assign we_head[q] = cpu_we && (cpu_addr == REG_AW'(2 + 2*q));
      assign we_tail[q] = cpu_we && (cpu_addr == REG_AW'(3 + 2*q));

      cq_queue #(
        .Q(q), .CODE_W(CODE_W), .PTR_W(PTR_W), .UNIT_SHIFT(UNIT_SHIFT),
        .HW_ON_HEAD((q == int'(RING_IN_POST)) || (q == int'(RING_OUT_FREE)))
      ) u_ring (
        .clk(clk), .rst_n(rst_n), .run(run), .code(code),
        .we_head(we_head[q]), .we_tail(we_tail[q]), .wval(wval),
        .hw_adv(hw_adv[q]), .head(head_r[q]), .tail(tail_r[q]),
        .hw_ptr(hwp[q]), .empty(q_empty[q]), .full(q_full[q]),
        .err_q(hw_err[q]), .acc_q(acc_q[q])
      );

      assign hw_addr[q*ADDR_W +: ADDR_W] = {base_hi, LOW_ZERO'(0)} + ADDR_W'(hwp[q]);
    end
  endgenerate

  assign ip_post_pulse = acc_q[RING_IN_POST];

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == REG_AW'(0)) cpu_rdata = ADDR_W'({code, en});
    if (cpu_addr == REG_AW'(1)) cpu_rdata = {base_hi, LOW_ZERO'(0)};
    for (int q = 0; q < NQ; q++) begin
      if (cpu_addr == REG_AW'(2 + 2*q)) cpu_rdata = ADDR_W'(head_r[q]);
      if (cpu_addr == REG_AW'(3 + 2*q)) cpu_rdata = ADDR_W'(tail_r[q]);
    end
  end

  AST_POST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ip_post_pulse |-> $past(hw_adv[RING_IN_POST] && run)); // R9
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ip_post_pulse && !hw_adv[RING_IN_POST] |=> !ip_post_pulse); // R9
endmodule

// File: tb/cq_ptr_mgr_test.sv
module cq_ptr_mgr_test;
  localparam int UNIT = 16384;
  localparam logic [31:0] BASE = 32'hABC0_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_we = 1'b0;
  logic [3:0]   cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic [3:0]   hw_adv = '0;
  logic [127:0] hw_addr;
  logic [3:0]   q_empty, q_full, hw_err;
  logic         ip_post_pulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cq_ptr_mgr uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .hw_adv(hw_adv),
    .hw_addr(hw_addr), .q_empty(q_empty), .q_full(q_full),
    .hw_err(hw_err), .ip_post_pulse(ip_post_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    cpu_addr = a;
    #1;
    chk(req, cpu_rdata, exp);
  endtask

  task automatic adv(input logic [3:0] m);
    @(negedge clk);
    hw_adv = m;
    @(negedge clk);
    hw_adv = '0;
    #1;
  endtask

  // model step: offset inside the region taken modulo the region size
  function automatic logic [31:0] mstep(input logic [31:0] p, input logic [31:0] st,
                                        input logic [31:0] sz);
    return st + ((p - st + 32'd4) % sz);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 10; a++) rd_chk("R11 reg reset", 4'(a), 32'h0);
    chk("R11 empty", 32'(q_empty), 32'hF);
    chk("R11 full", 32'(q_full), 32'h0);
    chk("R11 err", 32'(hw_err), 32'h0);
    chk("R11 pulse", 32'(ip_post_pulse), 32'h0);
    chk("R11 addr", hw_addr[31:0] | hw_addr[127:96], 32'h0);

    // R1 / R2
    wr(0, 32'hFFFF_FFC5);
    rd_chk("R1 control readback", 0, 32'h05);
    wr(1, 32'hABCD_E123);
    rd_chk("R2 base masked", 1, BASE);

    // R3 pointer bit handling
    wr(2, 32'h0000_1237);
    rd_chk("R3 low bits dropped", 2, 32'h1234);
    wr(2, 32'hFFFF_FFFF);
    rd_chk("R3 high bits dropped", 2, 32'h001F_FFFC);
    for (int q = 0; q < 4; q++) begin
      wr(4'(2 + 2*q), 32'(q * 2 * UNIT));
      wr(4'(3 + 2*q), 32'(q * 2 * UNIT));
      rd_chk("R3 head placement", 4'(2 + 2*q), 32'(q * 2 * UNIT));
      rd_chk("R3 tail placement", 4'(3 + 2*q), 32'(q * 2 * UNIT));
    end

    // R7 tail-side strobes on empty rings are refused
    adv(4'b0101);
    chk("R7 empty refusal err", 32'(hw_err), 32'h5);
    rd_chk("R7 tail held ring0", 3, 32'h0);
    rd_chk("R7 tail held ring2", 7, 32'(4 * UNIT));
    @(negedge clk); #1;
    chk("R7 err one cycle", 32'(hw_err), 32'h0);

    // R4 R5 R6 R7 R9 sweep over rings and size codes
    for (int code = 1; code <= 3; code++) begin
      for (int q = 0; q < 4; q++) begin
        logic [31:0] st, sz, h, t, hp;
        bit on_head, blk;
        st = 32'(q * code * UNIT);
        sz = 32'(code * UNIT);
        on_head = (q == 1) || (q == 3);
        wr(0, 32'((code << 1) | 1));
        hp = st + sz - 32'd8;
        h = on_head ? hp : st + 32'd4;
        t = on_head ? st + 32'd4 : hp;
        wr(4'(2 + 2*q), h);
        wr(4'(3 + 2*q), t);
        for (int k = 0; k < 4; k++) begin
          blk = on_head ? (mstep(h, st, sz) == t) : (h == t);
          adv(4'(1 << q));
          if (!blk) begin
            if (on_head) h = mstep(h, st, sz);
            else         t = mstep(t, st, sz);
          end
          hp = on_head ? h : t;
          chk("R7 err bit", 32'(hw_err), blk ? 32'(1 << q) : 32'h0);
          chk("R9 post pulse", 32'(ip_post_pulse), 32'((q == 1) && !blk));
          chk("R5 address lane", hw_addr[q*32 +: 32], BASE + hp);
          rd_chk("R4 pointer step/wrap", 4'(on_head ? 2 + 2*q : 3 + 2*q), hp);
          chk("R6 empty flag", 32'(q_empty[q]), 32'(h == t));
          chk("R6 full flag", 32'(q_full[q]), 32'(mstep(h, st, sz) == t));
        end
      end
    end

    // R8 disabled, then zero size code
    begin
      logic [31:0] h1;
      h1 = 32'(3 * UNIT);
      wr(0, 32'h02);
      wr(4, h1 - 32'd64);
      wr(5, h1 - 32'd128);
      adv(4'hF);
      chk("R8 disabled err", 32'(hw_err), 32'h0);
      chk("R8 disabled pulse", 32'(ip_post_pulse), 32'h0);
      rd_chk("R8 disabled head", 4, h1 - 32'd64);
      wr(0, 32'h01);
      adv(4'hF);
      chk("R8 zero code err", 32'(hw_err), 32'h0);
      chk("R8 zero code pulse", 32'(ip_post_pulse), 32'h0);
      rd_chk("R8 zero code head", 4, h1 - 32'd64);
    end

    // R10 same-cycle write and strobe on the inbound post ring, size code 1
    wr(0, 32'h03);
    wr(4, 32'(UNIT));
    wr(5, 32'(UNIT));
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 4; cpu_wdata = 32'(UNIT + 40); hw_adv = 4'b0010;
    @(negedge clk);
    cpu_we = 1'b0; hw_adv = '0;
    #1;
    chk("R10 write beats strobe pulse", 32'(ip_post_pulse), 32'h1);
    rd_chk("R10 write beats strobe head", 4, 32'(UNIT + 40));
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 5; cpu_wdata = 32'(UNIT + 8); hw_adv = 4'b0010;
    @(negedge clk);
    cpu_we = 1'b0; hw_adv = '0;
    #1;
    chk("R10 both pulse", 32'(ip_post_pulse), 32'h1);
    rd_chk("R10 both head stepped", 4, 32'(UNIT + 44));
    rd_chk("R10 both tail written", 5, 32'(UNIT + 8));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule